// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is an eight-stage parallel-in, serial-out shift register. An active-low load input copies a parallel word into all stages with no clock edge needed, and holds off shifting for as long as it stays asserted. Two clock inputs are combined by a logical OR. Each rising edge of that combination moves the register one place toward the last stage, with a serial input filling the first stage. Because of the OR, either clock input can act as an active-low enable for the other. The last stage is driven out in true and inverted form, and the serial input allows several registers to be chained.

All control inputs are treated as asynchronous. They are brought into one free-running system clock through two-flop synchronizers. A shift happens on the system-clock cycle after a rising edge of the synchronized OR is seen. The load input and the parallel word do not depend on the two clock inputs.

Top module: `dual_clk_piso`

## Requirements
- R1: While `rst_ni` is low, every stage is 0, so `q_o` is 0 and `q_n_o` is 1. The clock synchronizers reset to high, so a clock input held high through reset release causes no shift.
- R2: While `load_ni` is low, the stages copy `par_i`, with stage k taking `par_i[k]`. `q_o` therefore shows `par_i[7]`, and the stages follow `par_i` when it changes during the load.
- R3: Rising edges on the combined clock while `load_ni` is low leave the register holding the parallel word.
- R4: On a shift, `ser_i` enters stage 0 and stage k takes the old stage k-1. After a load, bits leave at `q_o` from `par_i[7]` down to `par_i[0]`.
- R5: `q_n_o` is always the inverse of `q_o`.
- R6: A shift occurs once for each low-to-high transition of `clk_a_i | clk_b_i`, and at no other time.
- R7: While either clock input is high, activity on the other clock input does not change the register.
- R8: Raising one clock input while the other is low causes exactly one shift. Raising it while the other is high causes none.
- R9: A combined-clock rising edge that is synchronized in the same cycle in which the load release is synchronized is ignored. Shifting resumes on the next rising edge.
- R10: An input change made between system clock edges shows up at `q_o` after the third following rising edge of `clk_i`, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_ni | input | 1 | Active-low parallel load, asynchronous |
| clk_a_i | input | 1 | First shift clock or enable, asynchronous |
| clk_b_i | input | 1 | Second shift clock or enable, asynchronous |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | 8 | Parallel word, bit k loads stage k |
| q_o | output | 1 | Last stage, true |
| q_n_o | output | 1 | Last stage, inverted |

## Verification
Only the last stage is visible, so a wrong bit held in an inner stage stays hidden until enough shifts carry it out. A fault in stage k shows at `q_o` after 7-k further shifts. The bench therefore shifts every loaded word all the way out, and after reset it shifts seven zeros so that a spurious reset-time shift would surface. A wrong edge decision, such as an extra shift from a held clock or a missing shift from an enable rising, offsets every later bit by one place and shows on the next check. An error in the synchronizer depth shows as a latency that is not exactly three edges.

// File: rtl/piso_pkg.sv
package piso_pkg;
  parameter int unsigned DEF_WIDTH = 8;
  parameter int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic load_n;
    logic clk_a;
    logic clk_b;
    logic ser;
  } piso_async_t;

  localparam int unsigned ASYNC_W = $bits(piso_async_t);
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = chain_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else         chain_q[g] <= src;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_a_s_i,
  input  logic clk_b_s_i,
  input  logic ld_n_s_i,
  output logic or_s_o,
  output logic or_q_o,
  output logic ld_q_o,
  output logic shift_o
);
  logic or_s, or_q, ld_q;

  assign or_s = clk_a_s_i | clk_b_s_i;

  // history resets high: a clock held high across reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      or_q <= 1'b1;
      ld_q <= 1'b1;
    end else begin
      or_q <= or_s;
      ld_q <= ld_n_s_i;
    end
  end

  // edge consumed even during load; release cycle itself does not shift
  assign shift_o = or_s & ~or_q & ld_n_s_i & ld_q;
  assign or_s_o  = or_s;
  assign or_q_o  = or_q;
  assign ld_q_o  = ld_q;
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] stage_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (load_i)  stage_q <= par_i;
    else if (shift_i) stage_q <= {stage_q[W-2:0], ser_i};
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/dual_clk_piso.sv
module dual_clk_piso
  import piso_pkg::*;
#(
  parameter int unsigned W         = DEF_WIDTH,
  parameter int unsigned SYNC_LEN  = DEF_SYNC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic         q_o,
  output logic         q_n_o
);
  localparam piso_async_t SYNC_RST = '{load_n: 1'b1, clk_a: 1'b1, clk_b: 1'b1, ser: 1'b0};

  piso_async_t raw, syn;
  logic        or_s, or_q, ld_q, shift_en;
  logic [W-1:0] stage_q;

  assign raw = '{load_n: load_ni, clk_a: clk_a_i, clk_b: clk_b_i, ser: ser_i};

  piso_sync #(
    .W      (ASYNC_W),
    .STAGES (SYNC_LEN),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  piso_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_a_s_i(syn.clk_a),
    .clk_b_s_i(syn.clk_b),
    .ld_n_s_i (syn.load_n),
    .or_s_o   (or_s),
    .or_q_o   (or_q),
    .ld_q_o   (ld_q),
    .shift_o  (shift_en)
  );

  piso_stages #(.W(W)) u_stages (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~syn.load_n),
    .shift_i(shift_en),
    .ser_i  (syn.ser),
    .par_i  (par_i),
    .stage_o(stage_q)
  );

  assign q_o   = stage_q[W-1];
  assign q_n_o = ~stage_q[W-1];
endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ld_n_s,
  input logic         or_s,
  input logic         or_q,
  input logic         shift_en,
  input logic         ser_s,
  input logic [W-1:0] par_i,
  input logic [W-1:0] stage_q,
  input logic         q_o,
  input logic         q_n_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (q_o == 1'b0 && q_n_o == 1'b1);
    end
  end

  a_r2_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_n_s |=> stage_q == $past(par_i));

  a_r9_release_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_n_s) |=> $stable(stage_q));

  a_r4_shift_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> stage_q == {$past(stage_q[W-2:0]), $past(ser_s)});

  a_r5_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_n_o == ~q_o);

  a_r6_only_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_n_s && !shift_en) |=> $stable(stage_q));

  a_r7_hold_when_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_n_s && or_s && or_q) |=> $stable(stage_q));
endmodule

bind dual_clk_piso piso_checker #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ld_n_s  (syn.load_n),
  .or_s    (or_s),
  .or_q    (or_q),
  .shift_en(shift_en),
  .ser_s   (syn.ser),
  .par_i   (par_i),
  .stage_q (stage_q),
  .q_o     (q_o),
  .q_n_o   (q_n_o)
);

// File: tb/dual_clk_piso_tb.sv
module dual_clk_piso_tb;
  localparam int SETTLE = 6;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_n = 1'b1, ca = 1'b1, cb = 1'b0, ser = 1'b1;
  logic [7:0] par = 8'h00;
  logic q, qn;

  int checks = 0, errors = 0;
  logic [7:0] model = 8'h00;
  logic prev_or = 1'b1, prev_ld = 1'b1;
  item_t sb[$];
  event chk_ev;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_clk_piso u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .clk_a_i(ca), .clk_b_i(cb),
    .ser_i(ser), .par_i(par), .q_o(q), .q_n_o(qn)
  );

  task automatic check(input logic act_q, input logic act_qn, input logic exp_q, input string tag);
    checks++;
    if (act_q !== exp_q || act_qn !== ~exp_q) begin
      errors++;
      $display("FAIL %s: q=%b q_n=%b expected q=%b q_n=%b", tag, act_q, act_qn, exp_q, ~exp_q);
    end
  endtask

  // driver: apply inputs, predict, queue, let settle, release monitor
  task automatic drive(input logic ln, input logic a, input logic b, input logic s,
                       input logic [7:0] p, input string tag);
    item_t it;
    logic now_or;
    @(negedge clk);
    load_n = ln; ca = a; cb = b; ser = s; par = p;
    now_or = a | b;
    if (!ln) model = p;
    else if (prev_ld && now_or && !prev_or) model = {model[6:0], s};
    prev_or = now_or;
    prev_ld = ln;
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
    repeat (SETTLE) @(negedge clk);
    -> chk_ev;
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      @(chk_ev);
      it = sb.pop_front();
      check(q, qn, it.exp[7], it.tag);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(q, qn, 1'b0, "R1 reset value");
    rst_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check(q, qn, 1'b0, "R1 after release");
    // clk_a held high through reset with ser=1: a spurious shift would surface after 7 zeros
    drive(1, 0, 0, 0, 8'h00, "R1 fall no shift");
    for (int i = 0; i < 7; i++) begin
      drive(1, 0, 1, 0, 8'h00, "R1 no reset-time shift");
      drive(1, 0, 0, 0, 8'h00, "R6 falling edge holds");
    end

    // load and load priority
    drive(0, 0, 0, 0, 8'hA5, "R2 load msb");
    drive(0, 0, 1, 1, 8'hA5, "R3 edge during load");
    drive(0, 0, 0, 1, 8'hA5, "R3 fall during load");
    drive(0, 0, 0, 1, 8'h3C, "R2 follows par during load");
    drive(0, 0, 0, 1, 8'hC5, "R2 reload");
    drive(1, 0, 0, 1, 8'hC5, "R2 release holds word");
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 1, i[0], 8'h00, "R4 shift order");
      drive(1, 0, 0, i[0], 8'h00, "R4 hold between");
    end

    // enable behaviour
    drive(0, 0, 0, 0, 8'hAA, "R2 load AA");
    drive(1, 0, 0, 0, 8'hAA, "R2 release");
    drive(1, 1, 0, 1, 8'h00, "R6 clk_a rising shifts");
    drive(1, 1, 1, 0, 8'h00, "R7 clk_b rise while clk_a high");
    drive(1, 1, 0, 0, 8'h00, "R7 clk_b fall while clk_a high");
    drive(1, 1, 1, 1, 8'h00, "R7 clk_b rise again");
    drive(1, 0, 1, 1, 8'h00, "R7 clk_a fall while clk_b high");
    drive(1, 1, 1, 0, 8'h00, "R8 enable up with clock high");
    drive(1, 1, 0, 0, 8'h00, "R7 clk_b fall, held by enable");
    drive(1, 0, 0, 0, 8'h00, "R8 enable down, clock low");
    drive(1, 1, 0, 1, 8'h00, "R8 enable up with clock low shifts");
    drive(1, 0, 0, 1, 8'h00, "R8 enable down");
    drive(1, 0, 1, 0, 8'h00, "R6 shift after enable");
    drive(1, 0, 0, 0, 8'h00, "R6 clock low");

    // release coinciding with rising edge
    drive(0, 0, 0, 0, 8'h80, "R2 load 80");
    drive(1, 0, 1, 0, 8'h80, "R9 edge in release cycle ignored");
    drive(1, 0, 0, 0, 8'h80, "R9 fall");
    drive(1, 0, 1, 0, 8'h80, "R9 next edge shifts");

    // latency: stage7 is 0 now; load 80 then shift once
    drive(0, 0, 0, 0, 8'h80, "R10 load 80");
    drive(1, 0, 0, 0, 8'h80, "R10 release");
    @(negedge clk);
    cb = 1'b1; ser = 1'b0;
    model = {model[6:0], 1'b0};
    prev_or = 1'b1;
    @(negedge clk);
    check(q, qn, 1'b1, "R10 unchanged after 1 edge");
    @(negedge clk);
    check(q, qn, 1'b1, "R10 unchanged after 2 edges");
    @(negedge clk);
    check(q, qn, model[7], "R10 shifted after 3 edges");
    repeat (SETTLE) @(negedge clk);
    check(q, qn, model[7], "R5 complement steady");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule